// File: doc/BRIEF.md
# Zoned EEPROM Write Sequencer

This block sits between a command decoder and a nonvolatile array model. It takes writes into a user space of eight zones of 128 bytes, 1024 bytes in all. A write opens with a start request that carries a zone number and an offset inside the zone. The requested zone's write-permission bit is checked at that moment. A refused request raises a one-cycle denial and the block stays idle. An admitted request is acknowledged, and data bytes then fill a 16-byte page buffer until a byte is flagged as the last one.

A single-byte write is a page write that holds one byte. Bytes land in consecutive columns starting at the offset's column. If more bytes arrive than remain before the page boundary, they wrap to the start of the same aligned page, and a later byte replaces an earlier one in the same column. Once the last byte is in, the block becomes busy. It scans the buffer and issues one array strobe per filled column, in ascending address order. It then waits out a self-timed write cycle whose length in system clocks is a parameter. While busy, new start requests get no acknowledge, so a polling host sees the write still in progress. An abort before the last byte throws the buffer away and leaves the array untouched.

Top module: `zone_write_seq`

## Requirements
- R1: After reset, `busy`, `cmd_ack`, `wr_deny` and `arr_we` are all low.
- R2: A `cmd_start` sampled while the block is idle, naming a zone whose bit in `zone_wr_en` is 1 (bit index equals zone number), gives `cmd_ack` high for exactly the next cycle and no `wr_deny`.
- R3: A `cmd_start` sampled while idle, naming a zone whose `zone_wr_en` bit is 0, gives `wr_deny` high for exactly the next cycle and no `cmd_ack`. Any data bytes that follow, including one flagged last, cause no strobe and no busy period.
- R4: A write of one byte at zone Z and offset F produces exactly one strobe, with `arr_addr` = Z*128 + F and `arr_data` equal to the byte.
- R5: Bytes of a page write go to consecutive columns of the aligned 16-byte page containing the start offset: address = Z*128 + (F & 0x70) + ((F + i) mod 16) for byte i. After column 15 they wrap to column 0 of the same page. No address outside that page is written.
- R6: With more than 16 bytes, a later byte replaces the earlier byte of the same column. Strobes come in ascending address order, one per filled column.
- R7: Nothing reaches the array before the byte flagged with `dat_last`. A `cmd_abort` before that discards the buffer: no strobe, no busy period, and the block returns to idle.
- R8: When `cmd_abort` and a byte flagged last are sampled in the same cycle, the abort wins and the array is unchanged.
- R9: `busy` rises in the cycle after the last byte is sampled and stays high for exactly 16 + WR_CYCLES cycles. `arr_we` is only ever high while `busy` is high.
- R10: A `cmd_start` sampled while busy or while collecting data, including in the final busy cycle, gives neither `cmd_ack` nor `wr_deny`.
- R11: Data bytes presented while the block is idle are ignored: no strobe and no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Open a write at `cmd_zone` / `cmd_offset` |
| cmd_zone | input | 3 | Target zone number |
| cmd_offset | input | 7 | Byte offset inside the zone |
| cmd_abort | input | 1 | Drop the write being collected |
| dat_valid | input | 1 | Data byte present |
| dat_data | input | 8 | Data byte |
| dat_last | input | 1 | Marks the final byte of the write |
| zone_wr_en | input | 8 | Write permission per zone, bit n for zone n |
| cmd_ack | output | 1 | One-cycle acknowledge of an admitted start |
| wr_deny | output | 1 | One-cycle pulse on a start into a protected zone |
| busy | output | 1 | Commit scan and self-timed write cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 10 | Array byte address |
| arr_data | output | 8 | Array write data |

## Verification
Two events can fall in the same cycle. The first is the end of a write cycle and a new start request. The bench raises `cmd_start` in the very last cycle that `busy` is high. It expects no acknowledge, and then expects an acknowledge when the request is repeated one cycle later. The second is an abort and the byte flagged last. The bench drives both together and judges by the array model kept in the bench: it must receive no strobe and must never see `busy`.

// File: rtl/zws_pkg.sv
package zws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_BURN = 2'd2,
    ST_HOLD = 2'd3
  } zws_state_e;
endpackage

// File: rtl/zws_gate.sv
// Admission of a start request: permission lookup, ack and deny pulses.
module zws_gate #(
  parameter int ZONES  = 8,
  parameter int ZONE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ZONE_W-1:0] zone,
  input  logic [ZONES-1:0]  zone_wr_en,
  input  logic              idle,
  output logic              accept,
  output logic              ack_q,
  output logic              deny_q
);
  logic perm;
  logic ack_d;
  logic deny_d;

  always_comb begin
    perm   = zone_wr_en[zone];
    accept = start && idle && perm;
    ack_d  = accept;
    deny_d = start && idle && !perm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      deny_q <= 1'b0;
    end else begin
      ack_q  <= ack_d;
      deny_q <= deny_d;
    end
  end
endmodule

// File: rtl/zws_page_buf.sv
// Page staging buffer: one register per column, fill mask, wrapping pointer.
module zws_page_buf #(
  parameter int DATA_W    = 8,
  parameter int PAGE_BYTES = 16,
  parameter int PAGE_ID_W = 6,
  localparam int COL_W    = $clog2(PAGE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [PAGE_ID_W-1:0] base_page,
  input  logic [COL_W-1:0]     base_col,
  input  logic                 wr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [COL_W-1:0]     rd_slot,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_valid,
  output logic [PAGE_ID_W-1:0] page_q
);
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q, mask_d;
  logic [COL_W-1:0]      ptr_q, ptr_d;
  logic [PAGE_ID_W-1:0]  page_d;

  always_comb begin
    mask_d = mask_q;
    ptr_d  = ptr_q;
    page_d = page_q;
    if (load) begin
      mask_d = '0;
      ptr_d  = base_col;
      page_d = base_page;
    end else if (wr) begin
      mask_d[ptr_q] = 1'b1;
      ptr_d         = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
      page_q <= '0;
    end else begin
      mask_q <= mask_d;
      ptr_q  <= ptr_d;
      page_q <= page_d;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr && (ptr_q == COL_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) slot_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data  = slot_q[rd_slot];
    rd_valid = mask_q[rd_slot];
  end
endmodule

// File: rtl/zws_timer.sv
// Self-timed write cycle counter, loaded with the cycle length minus one.
module zws_timer #(
  parameter int WR_CYCLES = 500000,
  localparam int TMR_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                    cnt_d = TMR_W'(WR_CYCLES - 1);
    else if (run && cnt_q != '0) cnt_d = cnt_q - 1'b1;
    done = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/zws_ctrl.sv
// Sequencing: collect, scan the buffer into the array, hold for the write time.
module zws_ctrl
  import zws_pkg::*;
#(
  parameter int PAGE_BYTES = 16,
  localparam int COL_W     = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             dat_valid,
  input  logic             dat_last,
  input  logic             cmd_abort,
  input  logic             tmr_done,
  output zws_state_e       state_q,
  output logic [COL_W-1:0] slot_q,
  output logic             tmr_load,
  output logic             buf_wr
);
  zws_state_e       state_d;
  logic [COL_W-1:0] slot_d;
  logic             scan_end;

  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    tmr_load = 1'b0;
    buf_wr   = 1'b0;
    scan_end = (slot_q == COL_W'(PAGE_BYTES - 1));
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = ST_FILL;
      end
      ST_FILL: begin
        if (cmd_abort) begin
          state_d = ST_IDLE;
        end else if (dat_valid) begin
          buf_wr = 1'b1;
          if (dat_last) begin
            state_d = ST_BURN;
            slot_d  = '0;
          end
        end
      end
      ST_BURN: begin
        slot_d = slot_q + 1'b1;
        if (scan_end) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
        end
      end
      ST_HOLD: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end
endmodule

// File: rtl/zone_write_seq.sv
module zone_write_seq
  import zws_pkg::*;
#(
  parameter int ZONES      = 8,
  parameter int ZONE_BYTES = 128,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int WR_CYCLES  = 500000,
  localparam int ZONE_W    = $clog2(ZONES),
  localparam int OFF_W     = $clog2(ZONE_BYTES),
  localparam int COL_W     = $clog2(PAGE_BYTES),
  localparam int ROW_W     = OFF_W - COL_W,
  localparam int PAGE_ID_W = ZONE_W + ROW_W,
  localparam int ADDR_W    = ZONE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ZONE_W-1:0] cmd_zone,
  input  logic [OFF_W-1:0]  cmd_offset,
  input  logic              cmd_abort,
  input  logic              dat_valid,
  input  logic [DATA_W-1:0] dat_data,
  input  logic              dat_last,
  input  logic [ZONES-1:0]  zone_wr_en,
  output logic              cmd_ack,
  output logic              wr_deny,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);
  zws_state_e           state;
  logic [COL_W-1:0]     slot;
  logic                 accept;
  logic                 tmr_load;
  logic                 tmr_done;
  logic                 buf_wr;
  logic [DATA_W-1:0]    rd_data;
  logic                 rd_valid;
  logic [PAGE_ID_W-1:0] page_q;
  logic                 is_idle;

  assign is_idle = (state == ST_IDLE);

  zws_gate #(.ZONES(ZONES), .ZONE_W(ZONE_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .start(cmd_start), .zone(cmd_zone),
    .zone_wr_en(zone_wr_en), .idle(is_idle), .accept(accept),
    .ack_q(cmd_ack), .deny_q(wr_deny)
  );

  zws_ctrl #(.PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(accept), .dat_valid(dat_valid),
    .dat_last(dat_last), .cmd_abort(cmd_abort), .tmr_done(tmr_done),
    .state_q(state), .slot_q(slot), .tmr_load(tmr_load), .buf_wr(buf_wr)
  );

  zws_page_buf #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .PAGE_ID_W(PAGE_ID_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .base_page({cmd_zone, cmd_offset[OFF_W-1:COL_W]}),
    .base_col(cmd_offset[COL_W-1:0]), .wr(buf_wr), .wr_data(dat_data),
    .rd_slot(slot), .rd_data(rd_data), .rd_valid(rd_valid), .page_q(page_q)
  );

  zws_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(state == ST_HOLD),
    .done(tmr_done)
  );

  always_comb begin
    busy     = (state == ST_BURN) || (state == ST_HOLD);
    arr_we   = (state == ST_BURN) && rd_valid;
    arr_addr = {page_q, slot};
    arr_data = rd_data;
  end
endmodule

// File: rtl/zone_write_seq_chk.sv
module zone_write_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_start,
  input logic cmd_ack,
  input logic wr_deny,
  input logic busy,
  input logic arr_we
);
  // R9: strobes only inside the busy window
  a_r9_we_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R2: acknowledge lasts one cycle
  a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |=> !cmd_ack);

  // R3: denial lasts one cycle
  a_r3_deny_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_deny |=> !wr_deny);

  // R3: denial never coincides with acknowledge or a busy period
  a_r3_deny_alone: assert property (@(posedge clk) disable iff (!rst_n)
    wr_deny |-> (!cmd_ack && !busy));

  // R10: a start while busy gets no answer
  a_r10_refuse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && busy) |=> (!cmd_ack && !wr_deny));

  // R2: an acknowledge is never given while busy
  a_r2_ack_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ack |-> !busy);
endmodule

bind zone_write_seq zone_write_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_ack(cmd_ack),
  .wr_deny(wr_deny), .busy(busy), .arr_we(arr_we)
);

// File: tb/zone_write_seq_tb_top.sv
module zone_write_seq_tb_top;
  localparam int WR     = 20;
  localparam int BUSY_N = 16 + WR;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_start, cmd_abort, dat_valid, dat_last;
  logic [2:0] cmd_zone;
  logic [6:0] cmd_offset;
  logic [7:0] dat_data;
  logic [7:0] zone_wr_en;
  logic       cmd_ack, wr_deny, busy, arr_we;
  logic [9:0] arr_addr;
  logic [7:0] arr_data;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int we_cnt = 0;
  logic [7:0] mem [1024];
  int log_addr [32];
  int log_n = 0;

  always #2 clk = ~clk;

  zone_write_seq #(.WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_zone(cmd_zone),
    .cmd_offset(cmd_offset), .cmd_abort(cmd_abort), .dat_valid(dat_valid),
    .dat_data(dat_data), .dat_last(dat_last), .zone_wr_en(zone_wr_en),
    .cmd_ack(cmd_ack), .wr_deny(wr_deny), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data)
  );

  // array model fed by the strobes
  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      mem[arr_addr] = arr_data;
      we_cnt++;
      if (log_n < 32) begin
        log_addr[log_n] = int'(arr_addr);
        log_n++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    we_cnt = 0;
    log_n  = 0;
  endtask

  task automatic do_start(input int z, input int off, output bit acked, output bit denied);
    @(negedge clk);
    cmd_start = 1'b1; cmd_zone = 3'(z); cmd_offset = 7'(off);
    @(negedge clk);
    cmd_start = 1'b0;
    acked = cmd_ack; denied = wr_deny;
    @(negedge clk);
    chk(!cmd_ack && !wr_deny, "R2 R3 pulse width", {cmd_ack, wr_deny}, 0);
  endtask

  task automatic send_bytes(input int n, input int base, input bit last, input bit abort_with_last,
                            input bit abort_after);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dat_valid = 1'b1; dat_data = 8'(base + i);
      dat_last  = last && (i == n - 1);
      cmd_abort = abort_with_last && (i == n - 1);
    end
    @(negedge clk);
    dat_valid = 1'b0; dat_last = 1'b0; cmd_abort = 1'b0;
    if (abort_after) begin
      cmd_abort = 1'b1;
      @(negedge clk);
      cmd_abort = 1'b0;
    end
  endtask

  // counts busy cycles; probe raises starts in the second and last busy cycles
  task automatic wait_busy(output int n, input bit probe);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (probe && n == 3) begin
        cmd_start = 1'b0;
        chk(!cmd_ack && !wr_deny, "R10 start in scan", {cmd_ack, wr_deny}, 0);
      end
      if (probe && n == 2)      begin cmd_start = 1'b1; cmd_zone = 3'd2; cmd_offset = 7'd0; end
      if (probe && n == BUSY_N) begin cmd_start = 1'b1; cmd_zone = 3'd4; cmd_offset = 7'd0; end
      @(negedge clk);
    end
    cmd_start = 1'b0;
    if (probe) chk(!cmd_ack && !wr_deny, "R10 start in final busy cycle", {cmd_ack, wr_deny}, 0);
  endtask

  task automatic quiet(input int n, input string req);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic t_reset();
    chk(!busy && !cmd_ack && !wr_deny && !arr_we, "R1 reset outputs",
        {busy, cmd_ack, wr_deny, arr_we}, 0);
  endtask

  task automatic t_single();
    bit a, d; int n;
    clr_log();
    do_start(3, 'h25, a, d);
    chk(a && !d, "R2 ack on permitted zone", {a, d}, 2);
    send_bytes(1, 'hA5, 1, 0, 0);
    wait_busy(n, 0);
    chk(n == BUSY_N, "R9 busy length", n, BUSY_N);
    chk(we_cnt == 1, "R4 one strobe", we_cnt, 1);
    chk(mem[3*128 + 'h25] == 8'hA5, "R4 byte location", mem[3*128 + 'h25], 'hA5);
  endtask

  task automatic t_page_wrap();
    bit a, d; int n; int base;
    clr_log();
    base = 5*128 + 16;
    do_start(5, 'h1C, a, d);
    chk(a, "R2 ack page", a, 1);
    send_bytes(6, 'h10, 1, 0, 0);
    wait_busy(n, 0);
    chk(we_cnt == 6, "R5 strobe count", we_cnt, 6);
    for (int i = 0; i < 6; i++) begin
      int col;
      col = (12 + i) % 16;
      chk(mem[base + col] == 8'('h10 + i), "R5 wrapped byte", mem[base + col], 'h10 + i);
    end
    chk(mem[5*128 + 32] == 8'h00, "R5 next page untouched", mem[5*128 + 32], 0);
    for (int i = 1; i < log_n; i++)
      chk(log_addr[i] > log_addr[i-1], "R6 ascending order", log_addr[i], log_addr[i-1] + 1);
  endtask

  task automatic t_overwrite();
    bit a, d; int n;
    clr_log();
    do_start(0, 'h40, a, d);
    send_bytes(18, 'h80, 1, 0, 0);
    wait_busy(n, 0);
    chk(we_cnt == 16, "R6 one strobe per column", we_cnt, 16);
    chk(mem['h40] == 8'h90, "R6 column 0 replaced", mem['h40], 'h90);
    chk(mem['h41] == 8'h91, "R6 column 1 replaced", mem['h41], 'h91);
    chk(mem['h4F] == 8'h8F, "R6 column 15 kept", mem['h4F], 'h8F);
  endtask

  task automatic t_deny();
    bit a, d;
    clr_log();
    do_start(2, 'h10, a, d);
    chk(d && !a, "R3 deny pulse", {a, d}, 1);
    send_bytes(2, 'h33, 1, 0, 0);
    quiet(BUSY_N, "R3 no busy after deny");
    chk(we_cnt == 0, "R3 no strobe after deny", we_cnt, 0);
  endtask

  task automatic t_abort();
    bit a, d;
    clr_log();
    do_start(1, 'h00, a, d);
    chk(a, "R7 ack", a, 1);
    send_bytes(3, 'h55, 0, 0, 1);
    quiet(BUSY_N, "R7 no busy after abort");
    chk(we_cnt == 0 && mem[128] == 8'h00, "R7 array unchanged", we_cnt, 0);
  endtask

  task automatic t_abort_last();
    bit a, d;
    clr_log();
    do_start(6, 'h30, a, d);
    send_bytes(2, 'h66, 1, 1, 0);
    quiet(BUSY_N, "R8 abort beats last");
    chk(we_cnt == 0 && mem[6*128 + 'h30] == 8'h00, "R8 array unchanged", we_cnt, 0);
  endtask

  task automatic t_refuse();
    bit a, d; int n;
    clr_log();
    do_start(4, 'h08, a, d);
    cmd_start = 1'b1; cmd_zone = 3'd4; cmd_offset = 7'd0;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(!cmd_ack && !wr_deny, "R10 start while collecting", {cmd_ack, wr_deny}, 0);
    send_bytes(1, 'h77, 1, 0, 0);
    wait_busy(n, 1);
    chk(n == BUSY_N, "R9 busy length with probes", n, BUSY_N);
    do_start(4, 'h00, a, d);
    chk(a, "R2 ack right after busy ends", a, 1);
    send_bytes(0, 0, 0, 0, 1);
    chk(mem[4*128 + 8] == 8'h77 && we_cnt == 1, "R10 write intact", mem[4*128 + 8], 'h77);
  endtask

  task automatic t_idle_data();
    clr_log();
    send_bytes(3, 'h99, 1, 0, 0);
    quiet(BUSY_N, "R11 idle data no busy");
    chk(we_cnt == 0, "R11 idle data no strobe", we_cnt, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    rst_n = 1'b0;
    cmd_start = 1'b0; cmd_abort = 1'b0; dat_valid = 1'b0; dat_last = 1'b0;
    cmd_zone = '0; cmd_offset = '0; dat_data = '0;
    zone_wr_en = 8'b1111_1011;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_page_wrap();
    t_overwrite();
    t_deny();
    t_abort();
    t_abort_last();
    t_refuse();
    t_idle_data();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule